// File: doc/BRIEF.md
# Four-Bit Arithmetic/Logic Slice with Group Carry Outputs

This block is a 4-bit arithmetic/logic slice meant to be tiled across a wide datapath. Two operands, a 4-bit function code and a mode bit pick one of sixteen bitwise logic functions or one of sixteen arithmetic functions. Each arithmetic function has the form X plus Y plus carry-in. X and Y are per-bit functions of the operands that the function code selects. The slice drives the result, a rippled carry-out, and two group terms: all-propagate and any-generate. An external second-level lookahead unit can use these group terms to form the carries of many slices in parallel.

The datapath is combinational. The top level registers the result and the three carry terms on the clock, so each applied input set is visible on the outputs one cycle later. In logic mode the carry input plays no part, and the carry-out and group terms are held low. In arithmetic mode a carry-in of 1 adds exactly one to the result.

Top module: `alu4_slice`

## Requirements
- R1: While rst_ni is low, f_o, cout_o, pg_o and gg_o are all 0. After reset, the outputs show the result of the inputs sampled at the previous rising clock edge.
- R2: When m_i=1 (logic mode), each result bit is a function of a_i[k] and b_i[k] chosen by s_i: 0000 A, 0001 A|B, 0010 A&B, 0011 all ones, 0100 ~A, 0101 ~(A|B), 0110 ~(A&B), 0111 A^B, 1000 B, 1001 ~B, 1010 ~(A^B), 1011 A&~B, 1100 all zeros, 1101 ~A&B, 1110 A|~B, 1111 A.
- R3: When m_i=1, cn_i has no effect on any output, and cout_o, pg_o and gg_o are 0.
- R4: When m_i=0 and s_i=0000, f_o = A plus cn_i.
- R5: When m_i=0 and s_i=0011, f_o = A plus A plus cn_i. When m_i=1, f_o is all ones.
- R6: When m_i=0 and s_i=1100, f_o = minus 1 plus cn_i (all ones, or 0 with carry-out when cn_i=1). When m_i=1, f_o is all zeros.
- R7: When m_i=0 and s_i=1111, f_o = A minus 1 plus cn_i.
- R8: When m_i=0, s_i=0001 gives A plus B plus cn_i, and s_i=0010 gives A minus B minus 1 plus cn_i (A plus ~B plus cn_i).
- R9: For the other arithmetic codes, f_o = X plus Y plus cn_i, with X, Y by code: 0100 A, A&B; 0101 A, A&~B; 0110 A|B, 0; 0111 A|B, A&~B; 1000 A&B, all ones; 1001 B, 0; 1010 B, B; 1011 B, ~A; 1101 A^B, 0; 1110 A&~B, all ones.
- R10: In arithmetic mode pg_o is 1 exactly when X plus Y equals 15, so a carry-in would pass through the whole slice.
- R11: In arithmetic mode gg_o is 1 exactly when X plus Y is at least 16, whatever cn_i is.
- R12: In arithmetic mode f_o is the low four bits of X plus Y plus cn_i, and cout_o equals gg_o OR (pg_o AND cn_i).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| s_i | input | 4 | Function code |
| m_i | input | 1 | Mode: 1 logic, 0 arithmetic |
| cn_i | input | 1 | Carry input |
| f_o | output | 4 | Registered result |
| cout_o | output | 1 | Registered carry-out of the slice |
| pg_o | output | 1 | Registered group propagate |
| gg_o | output | 1 | Registered group generate |

## Verification
The tricky case is an arithmetic cycle where the group-propagate condition and an active carry-in occur together. The carry-out then has to come from the propagate path, and the result wraps to zero, even though no bit generates a carry. The bench sweeps every code, mode, operand pair and carry value. This reaches every X plus Y equal to 15 with cn_i both 0 and 1. Every registered output is compared against an integer sum that the bench computes on its own, so an error in the ripple path and an error in the lookahead terms each show up as a mismatch.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef logic [3:0] tt_t;  // truth table indexed by {a,b}

  localparam tt_t TT_ZERO = 4'b0000;
  localparam tt_t TT_ONE  = 4'b1111;
  localparam tt_t TT_A    = 4'b1100;
  localparam tt_t TT_B    = 4'b1010;
  localparam tt_t TT_NA   = 4'b0011;
  localparam tt_t TT_NB   = 4'b0101;
  localparam tt_t TT_AND  = 4'b1000;
  localparam tt_t TT_OR   = 4'b1110;
  localparam tt_t TT_XOR  = 4'b0110;
  localparam tt_t TT_XNOR = 4'b1001;
  localparam tt_t TT_NOR  = 4'b0001;
  localparam tt_t TT_NAND = 4'b0111;
  localparam tt_t TT_ANB  = 4'b0100;
  localparam tt_t TT_NAB  = 4'b0010;
  localparam tt_t TT_AONB = 4'b1101;

  typedef enum logic {MODE_ARITH = 1'b0, MODE_LOGIC = 1'b1} mode_e;

  function automatic tt_t logic_tt(input logic [3:0] sel);
    case (sel)
      4'h0:    return TT_A;
      4'h1:    return TT_OR;
      4'h2:    return TT_AND;
      4'h3:    return TT_ONE;
      4'h4:    return TT_NA;
      4'h5:    return TT_NOR;
      4'h6:    return TT_NAND;
      4'h7:    return TT_XOR;
      4'h8:    return TT_B;
      4'h9:    return TT_NB;
      4'hA:    return TT_XNOR;
      4'hB:    return TT_ANB;
      4'hC:    return TT_ZERO;
      4'hD:    return TT_NAB;
      4'hE:    return TT_AONB;
      default: return TT_A;
    endcase
  endfunction

  function automatic tt_t addend_x_tt(input logic [3:0] sel);
    case (sel)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'hF: return TT_A;
      4'h6, 4'h7:                               return TT_OR;
      4'h8:                                     return TT_AND;
      4'h9, 4'hA, 4'hB:                         return TT_B;
      4'hD:                                     return TT_XOR;
      4'hE:                                     return TT_ANB;
      default:                                  return TT_ZERO;
    endcase
  endfunction

  function automatic tt_t addend_y_tt(input logic [3:0] sel);
    case (sel)
      4'h1:                   return TT_B;
      4'h2:                   return TT_NB;
      4'h3:                   return TT_A;
      4'h4:                   return TT_AND;
      4'h5, 4'h7:             return TT_ANB;
      4'hA:                   return TT_B;
      4'hB:                   return TT_NA;
      4'h8, 4'hC, 4'hE, 4'hF: return TT_ONE;
      default:                return TT_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/alu_operand_gen.sv
module alu_operand_gen
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       sel_i,
  output logic [WIDTH-1:0] x_o,
  output logic [WIDTH-1:0] y_o
);
  tt_t x_tt, y_tt;

  always_comb begin
    x_tt = addend_x_tt(sel_i);
    y_tt = addend_y_tt(sel_i);
  end

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign x_o[k] = x_tt[{a_i[k], b_i[k]}];
    assign y_o[k] = y_tt[{a_i[k], b_i[k]}];
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       sel_i,
  output logic [WIDTH-1:0] f_o
);
  tt_t fn_tt;

  always_comb fn_tt = logic_tt(sel_i);

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign f_o[k] = fn_tt[{a_i[k], b_i[k]}];
  end
endmodule

// File: rtl/alu_carry_tree.sv
module alu_carry_tree #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             pg_o,
  output logic             gg_o
);
  logic [WIDTH-1:0] prop, gen;
  logic [WIDTH:0]   carry;
  logic [WIDTH:0]   gacc;

  assign prop     = x_i ^ y_i;
  assign gen      = x_i & y_i;
  assign carry[0] = cin_i;
  assign gacc[0]  = 1'b0;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    // ripple path feeds sum and carry-out
    assign carry[k+1] = gen[k] | (prop[k] & carry[k]);
    assign sum_o[k]   = prop[k] ^ carry[k];
    // carry-free generate chain for the group term
    assign gacc[k+1]  = gen[k] | (prop[k] & gacc[k]);
  end

  assign cout_o = carry[WIDTH];
  assign pg_o   = &prop;
  assign gg_o   = gacc[WIDTH];
endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       s_i,
  input  logic             m_i,
  input  logic             cn_i,
  output logic [WIDTH-1:0] f_o,
  output logic             cout_o,
  output logic             pg_o,
  output logic             gg_o
);
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] x, y, sum, lres;
  logic             c_out, p_grp, g_grp;
  logic [WIDTH-1:0] f_d;
  logic             cout_d, pg_d, gg_d;
  mode_e            mode;

  assign mode = mode_e'(m_i);

  alu_operand_gen #(.WIDTH(WIDTH)) u_opgen (
    .a_i(a_i), .b_i(b_i), .sel_i(s_i), .x_o(x), .y_o(y)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i(a_i), .b_i(b_i), .sel_i(s_i), .f_o(lres)
  );

  alu_carry_tree #(.WIDTH(WIDTH)) u_carry (
    .x_i(x), .y_i(y), .cin_i(cn_i),
    .sum_o(sum), .cout_o(c_out), .pg_o(p_grp), .gg_o(g_grp)
  );

  always_comb begin
    if (mode == MODE_LOGIC) begin
      f_d    = lres;
      cout_d = 1'b0;
      pg_d   = 1'b0;
      gg_d   = 1'b0;
    end else begin
      f_d    = sum;
      cout_d = c_out;
      pg_d   = p_grp;
      gg_d   = g_grp;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_o    <= '0;
      cout_o <= 1'b0;
      pg_o   <= 1'b0;
      gg_o   <= 1'b0;
    end else begin
      f_o    <= f_d;
      cout_o <= cout_d;
      pg_o   <= pg_d;
      gg_o   <= gg_d;
    end
  end

  AST_LOGIC_FLAGS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_i |=> (!cout_o && !pg_o && !gg_o)); // R3
  AST_COUT_FROM_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_i |=> (cout_o == (gg_o | (pg_o & $past(cn_i))))); // R12
  AST_PG_EXCLUDES_GG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pg_o && gg_o)); // R10
  AST_LOGIC_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_i && s_i == 4'b0011) |=> (f_o == ONES)); // R5
  AST_LOGIC_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_i && s_i == 4'b1100) |=> (f_o == '0)); // R6
  AST_PASS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_i == 4'b0000 && (m_i || !cn_i)) |=> (f_o == $past(a_i))); // R4
endmodule

// File: tb/alu4_slice_tb.sv
module alu4_slice_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [3:0] a_i, b_i, s_i;
  logic       m_i, cn_i;
  logic [3:0] f_o;
  logic       cout_o, pg_o, gg_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  alu4_slice u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .s_i(s_i),
    .m_i(m_i), .cn_i(cn_i), .f_o(f_o), .cout_o(cout_o), .pg_o(pg_o), .gg_o(gg_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int logic_ref(input int s, input int a, input int b);
    case (s)
      0:  return a;
      1:  return a | b;
      2:  return a & b;
      3:  return 15;
      4:  return 15 - a;
      5:  return 15 - (a | b);
      6:  return 15 - (a & b);
      7:  return a ^ b;
      8:  return b;
      9:  return 15 - b;
      10: return 15 - (a ^ b);
      11: return a & (15 - b);
      12: return 0;
      13: return (15 - a) & b;
      14: return a | (15 - b);
      default: return a;
    endcase
  endfunction

  // returns {x, y} as x*16+y
  function automatic int addends(input int s, input int a, input int b);
    int x, y;
    case (s)
      0:  begin x = a;          y = 0;          end
      1:  begin x = a;          y = b;          end
      2:  begin x = a;          y = 15 - b;     end
      3:  begin x = a;          y = a;          end
      4:  begin x = a;          y = a & b;      end
      5:  begin x = a;          y = a & ~b & 15; end
      6:  begin x = a | b;      y = 0;          end
      7:  begin x = a | b;      y = a & ~b & 15; end
      8:  begin x = a & b;      y = 15;         end
      9:  begin x = b;          y = 0;          end
      10: begin x = b;          y = b;          end
      11: begin x = b;          y = 15 - a;     end
      12: begin x = 0;          y = 15;         end
      13: begin x = a ^ b;      y = 0;          end
      14: begin x = a & ~b & 15; y = 15;        end
      default: begin x = a;     y = 15;         end
    endcase
    return x * 16 + y;
  endfunction

  function automatic string sel_req(input int s, input int m);
    case (s)
      0:  return "R4";
      3:  return "R5";
      12: return "R6";
      15: return "R7";
      1, 2: return (m == 1) ? "R2" : "R8";
      default: return (m == 1) ? "R2" : "R9";
    endcase
  endfunction

  initial begin
    #3_000_000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    a_i = 4'd5; b_i = 4'd9; s_i = 4'd3; m_i = 1'b1; cn_i = 1'b1;
    repeat (3) @(negedge clk_i);
    // R1: reset state holds despite active inputs
    check("R1", "f_o reset", int'(f_o), 0);
    check("R1", "flags reset", int'({cout_o, pg_o, gg_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: one cycle after release the logic all-ones result is visible
    check("R1", "first result", int'(f_o), 15);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 16; s++) begin
        for (int a = 0; a < 16; a++) begin
          for (int b = 0; b < 16; b++) begin
            for (int c = 0; c < 2; c++) begin
              int xy, x, y, tot;
              string rq;
              m_i = 1'(m); s_i = 4'(s); a_i = 4'(a); b_i = 4'(b); cn_i = 1'(c);
              @(negedge clk_i);
              rq = sel_req(s, m);
              if (m == 1) begin
                check(rq, "logic f_o", int'(f_o), logic_ref(s, a, b));
                // R3: carry terms held low, cn_i irrelevant
                check("R3", "logic flags", int'({cout_o, pg_o, gg_o}), 0);
              end else begin
                xy  = addends(s, a, b);
                x   = xy / 16;
                y   = xy % 16;
                tot = x + y + c;
                check(rq, "arith f_o", int'(f_o), tot % 16);
                check("R10", "pg_o", int'(pg_o), (x + y == 15) ? 1 : 0);
                check("R11", "gg_o", int'(gg_o), (x + y > 15) ? 1 : 0);
                check("R12", "cout_o", int'(cout_o), (tot > 15) ? 1 : 0);
              end
            end
          end
        end
      end
    end

    // R1: asynchronous reset clears outputs without a clock edge
    m_i = 1'b0; s_i = 4'd12; cn_i = 1'b0;
    @(negedge clk_i);
    check("R6", "minus one", int'(f_o), 15);
    #2 rst_ni = 1'b0;
    #1 check("R1", "async clear", int'(f_o), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule